// File: doc/BRIEF.md
# Delayed Write Request Queue

This block sits behind a simplified initiator-bus front end and handles single-word writes that must not be posted: I/O writes and configuration writes aimed at a downstream bus. The first time such a write is attempted, the block claims it, tells the initiator to retry, and keeps the command, address, byte enables and data word in a small circular queue. The oldest entry is offered to a target-side engine. That engine reports success or failure with a one-cycle pulse.

When the initiator comes back with the same write, the block checks it against the stored entries. If a stored copy exists and the target side has not finished it yet, the answer is retry again and no second entry is made. If the oldest entry has finished and the retried attempt matches it exactly, the block returns completion and removes the entry. Data bytes whose enables are off take no part in that match. A completed entry that nobody collects is dropped once a programmable discard timer runs out.

The attempt channel has no back-pressure. Every cycle with `att_valid` high is sampled, and it gets exactly one response one cycle later. On the target channel, `tgt_valid` qualifies a stable head entry. A `tgt_done` or `tgt_err` pulse is accepted only in a cycle where `tgt_valid` is high. When `order_ok` is low, the block withdraws `tgt_valid` without losing the entry.

Top module: `dwq_top`

## Requirements
- R1: An attempt is eligible only if its command is 4'b0011 (I/O write) at any address, or 4'b1011 (configuration write) with address bits [1:0] equal to 2'b01. Any other attempt gets `rsp_valid` with `rsp_claim` low one cycle later, and the queue is left unchanged.
- R2: An eligible attempt whose command and address match no stored entry gets `rsp_claim` and `rsp_retry` one cycle later. If the queue is not full, the attempt is stored as a new pending entry.
- R3: `full` is high exactly when DEPTH entries are stored, and `empty` is high exactly when none are. A new attempt that arrives while the queue is full gets claim and retry, and no entry is made.
- R4: A repeat that matches a stored entry's command and address, but is not a full match to a finished head entry, gets claim and retry, and no new entry is made.
- R5: `tgt_valid` is high exactly when the head entry is pending and `order_ok` is high. While it is high, `tgt_cmd`/`tgt_addr`/`tgt_be_n`/`tgt_data` carry the head entry. `tgt_done`/`tgt_err` are ignored while it is low.
- R6: A repeat gets completion under these conditions: the head entry finished successfully, and the repeat's command, address and byte enables equal the stored ones and its enabled data bytes match. Completion means `rsp_claim` and `rsp_done` with `rsp_retry` low. The entry is then removed. If `att_multi` is high, `rsp_stop` is also raised.
- R7: Data byte k (bits 8k+7:8k) is excluded from the match when `att_be_n[k]` is 1, since the enables are active low.
- R8: A head entry finished with `tgt_err` (and without `tgt_done` in the same cycle, since done has priority) is answered on its matching repeat with `rsp_claim` and `rsp_abort`, and is then removed.
- R9: When the head entry finishes, a timer loads `discard_load`. If no matching repeat arrives, the entry is removed `discard_load`+1 cycles after the finishing cycle, and `discard` pulses for one cycle.
- R10: After reset the queue is empty, not full, and all response, target and discard outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| att_valid | input | 1 | Write attempt present this cycle |
| att_cmd | input | 4 | Attempt bus command |
| att_addr | input | 32 | Attempt address |
| att_be_n | input | 4 | Attempt byte enables, active low |
| att_data | input | 32 | Attempt data word |
| att_multi | input | 1 | Initiator requests more than one word |
| rsp_valid | output | 1 | Response to the previous cycle's attempt |
| rsp_claim | output | 1 | Access claimed |
| rsp_retry | output | 1 | Initiator must retry |
| rsp_done | output | 1 | Write completed (ready) |
| rsp_stop | output | 1 | Disconnect together with ready |
| rsp_abort | output | 1 | Stored write failed on the target side |
| order_ok | input | 1 | Ordering against posted data permits the head write |
| tgt_valid | output | 1 | Head entry offered to the target side |
| tgt_cmd | output | 4 | Head command |
| tgt_addr | output | 32 | Head address |
| tgt_be_n | output | 4 | Head byte enables |
| tgt_data | output | 32 | Head data |
| tgt_done | input | 1 | Head write finished successfully (pulse) |
| tgt_err | input | 1 | Head write failed (pulse) |
| discard_load | input | TMR_W | Discard timer load value |
| discard | output | 1 | A finished entry was dropped uncollected |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |

## Verification
The bench builds the block with DEPTH=4 and TMR_W=6. It draws addresses from a pool of five, so the queue regularly fills and the full-queue rejection is exercised under random traffic. Discard loads stay between 0 and 6, so timer expiry, including the zero-load case, happens within a few cycles. Data and enable pools differ only in byte 1, and one enable pattern masks exactly that byte, so masked and unmasked comparisons both occur often.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 32;
  localparam int BYTES  = 4;
  localparam int DATA_W = 8 * BYTES;

  localparam logic [CMD_W-1:0] CMD_IO_WR  = 4'b0011;
  localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {
    ST_PEND = 2'b00,
    ST_DONE = 2'b01,
    ST_FAIL = 2'b10
  } ent_st_e;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [BYTES-1:0]  be_n;
    logic [DATA_W-1:0] data;
  } dw_req_t;

  function automatic logic is_eligible(logic [CMD_W-1:0] cmd, logic [ADDR_W-1:0] addr);
    return (cmd == CMD_IO_WR) || ((cmd == CMD_CFG_WR) && (addr[1:0] == 2'b01));
  endfunction

  function automatic logic bytes_match(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                                       logic [BYTES-1:0] be_n);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < BYTES; k++) begin
      if (!be_n[k] && (a[8*k +: 8] != b[8*k +: 8])) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/dwq_store.sv
module dwq_store
  import dwq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  dw_req_t          push_req,
  input  logic             pop,
  input  logic             mark,
  input  ent_st_e          mark_st,
  output dw_req_t          slot_req [DEPTH],
  output logic [DEPTH-1:0] slot_vld,
  output dw_req_t          head_req,
  output ent_st_e          head_st,
  output logic [CW-1:0]    count
);
  dw_req_t         req_q [DEPTH];
  ent_st_e         st_q  [DEPTH];
  logic [PW-1:0]   hd_q, tl_q;

  function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd_q  <= '0;
      tl_q  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_PEND;
    end else begin
      if (push) begin
        st_q[tl_q] <= ST_PEND;
        tl_q       <= wrap_inc(tl_q);
      end
      if (mark) st_q[hd_q] <= mark_st;
      if (pop) hd_q <= wrap_inc(hd_q);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) req_q[tl_q] <= push_req;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    int off;
    always_comb begin
      off = (i >= int'(hd_q)) ? (i - int'(hd_q)) : (i + DEPTH - int'(hd_q));
      slot_vld[i] = (off < int'(count));
    end
    assign slot_req[i] = req_q[i];
  end

  assign head_req = req_q[hd_q];
  assign head_st  = st_q[hd_q];
endmodule

// File: rtl/dwq_match.sv
module dwq_match
  import dwq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  dw_req_t          att,
  input  dw_req_t          slot_req [DEPTH],
  input  logic [DEPTH-1:0] slot_vld,
  input  dw_req_t          head_req,
  output logic             hit_any,
  output logic             head_eq
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = slot_vld[i] &&
                        (slot_req[i].cmd == att.cmd) &&
                        (slot_req[i].addr == att.addr);
  end

  assign hit_any = |hit_vec;
  assign head_eq = (head_req.cmd == att.cmd) &&
                   (head_req.addr == att.addr) &&
                   (head_req.be_n == att.be_n) &&
                   bytes_match(head_req.data, att.data, att.be_n);
endmodule

// File: rtl/dwq_timer.sv
module dwq_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             hold,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (hold && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dwq_top.sv
module dwq_top
  import dwq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TMR_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              att_valid,
  input  logic [CMD_W-1:0]  att_cmd,
  input  logic [ADDR_W-1:0] att_addr,
  input  logic [BYTES-1:0]  att_be_n,
  input  logic [DATA_W-1:0] att_data,
  input  logic              att_multi,
  output logic              rsp_valid,
  output logic              rsp_claim,
  output logic              rsp_retry,
  output logic              rsp_done,
  output logic              rsp_stop,
  output logic              rsp_abort,
  input  logic              order_ok,
  output logic              tgt_valid,
  output logic [CMD_W-1:0]  tgt_cmd,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [BYTES-1:0]  tgt_be_n,
  output logic [DATA_W-1:0] tgt_data,
  input  logic              tgt_done,
  input  logic              tgt_err,
  input  logic [TMR_W-1:0]  discard_load,
  output logic              discard,
  output logic              full,
  output logic              empty
);
  dw_req_t          att_req, head_req;
  dw_req_t          slot_req [DEPTH];
  logic [DEPTH-1:0] slot_vld;
  ent_st_e          head_st;
  logic [CW-1:0]    count;
  logic             hit_any, head_eq, expired;
  logic             elig, head_fin, collect, drop_now, pop, push, tgt_evt;

  assign att_req = '{cmd: att_cmd, addr: att_addr, be_n: att_be_n, data: att_data};

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assign elig     = att_valid && is_eligible(att_cmd, att_addr);
  assign head_fin = !empty && (head_st != ST_PEND);
  assign collect  = elig && head_fin && head_eq;
  assign drop_now = head_fin && expired && !collect;
  assign pop      = collect || drop_now;
  assign push     = elig && !hit_any && !full;

  assign tgt_valid = !empty && (head_st == ST_PEND) && order_ok;
  assign tgt_evt   = tgt_valid && (tgt_done || tgt_err);
  assign tgt_cmd   = head_req.cmd;
  assign tgt_addr  = head_req.addr;
  assign tgt_be_n  = head_req.be_n;
  assign tgt_data  = head_req.data;

  dwq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_req (att_req),
    .pop      (pop),
    .mark     (tgt_evt),
    .mark_st  (tgt_done ? ST_DONE : ST_FAIL),
    .slot_req (slot_req),
    .slot_vld (slot_vld),
    .head_req (head_req),
    .head_st  (head_st),
    .count    (count)
  );

  dwq_match #(.DEPTH(DEPTH)) u_match (
    .att      (att_req),
    .slot_req (slot_req),
    .slot_vld (slot_vld),
    .head_req (head_req),
    .hit_any  (hit_any),
    .head_eq  (head_eq)
  );

  dwq_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tgt_evt),
    .load_val (discard_load),
    .hold     (head_fin && !pop),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_claim <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_stop  <= 1'b0;
      rsp_abort <= 1'b0;
      discard   <= 1'b0;
    end else begin
      rsp_valid <= att_valid;
      rsp_claim <= elig;
      rsp_retry <= elig && !collect;
      rsp_done  <= collect && (head_st == ST_DONE);
      rsp_stop  <= collect && (head_st == ST_DONE) && att_multi;
      rsp_abort <= collect && (head_st == ST_FAIL);
      discard   <= drop_now;
    end
  end
endmodule

// File: rtl/dwq_chk.sv
module dwq_chk (
  input logic clk,
  input logic rst_n,
  input logic rsp_valid,
  input logic rsp_claim,
  input logic rsp_retry,
  input logic rsp_done,
  input logic rsp_stop,
  input logic rsp_abort,
  input logic order_ok,
  input logic tgt_valid,
  input logic discard,
  input logic full,
  input logic empty
);
  // R3
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R6
  stop_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stop |-> rsp_done);

  // R4
  retry_vs_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |-> !(rsp_done || rsp_abort));

  // R2
  retry_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |-> rsp_claim);

  // R1
  claim_needs_att_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_claim |-> rsp_valid);

  // R5
  tgt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> order_ok);

  // R9
  discard_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> !$past(empty));

  // R8
  abort_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_retry, rsp_done, rsp_abort}));
endmodule

bind dwq_top dwq_chk u_chk (.*);

// File: tb/dwq_top_tb.sv
module dwq_top_tb;
  localparam int DEPTH = 4;
  localparam int TMR_W = 6;
  localparam logic [31:0] D0 = 32'h1122_3344;
  localparam logic [31:0] D1 = 32'h1122_AA44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic att_valid = 1'b0, att_multi = 1'b0;
  logic [3:0] att_cmd = '0, att_be_n = '0;
  logic [31:0] att_addr = '0, att_data = '0;
  logic order_ok = 1'b0, tgt_done = 1'b0, tgt_err = 1'b0;
  logic [TMR_W-1:0] discard_load = '0;
  logic rsp_valid, rsp_claim, rsp_retry, rsp_done, rsp_stop, rsp_abort;
  logic tgt_valid, discard, full, empty;
  logic [3:0] tgt_cmd, tgt_be_n;
  logic [31:0] tgt_addr, tgt_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dwq_top #(.DEPTH(DEPTH), .TMR_W(TMR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .att_valid(att_valid), .att_cmd(att_cmd),
    .att_addr(att_addr), .att_be_n(att_be_n), .att_data(att_data),
    .att_multi(att_multi), .rsp_valid(rsp_valid), .rsp_claim(rsp_claim),
    .rsp_retry(rsp_retry), .rsp_done(rsp_done), .rsp_stop(rsp_stop),
    .rsp_abort(rsp_abort), .order_ok(order_ok), .tgt_valid(tgt_valid),
    .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr), .tgt_be_n(tgt_be_n),
    .tgt_data(tgt_data), .tgt_done(tgt_done), .tgt_err(tgt_err),
    .discard_load(discard_load), .discard(discard), .full(full), .empty(empty)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  logic [3:0]  m_cmd  [DEPTH];
  logic [31:0] m_addr [DEPTH];
  logic [3:0]  m_be   [DEPTH];
  logic [31:0] m_data [DEPTH];
  int          m_st   [DEPTH];   // 0 pending, 1 done, 2 failed
  int          m_cnt = 0;
  int          m_tmr = 0;
  logic e_valid = 0, e_claim = 0, e_retry = 0, e_done = 0, e_stop = 0, e_abort = 0, e_disc = 0;

  function automatic logic ref_elig(logic [3:0] c, logic [31:0] a);
    return (c == 4'b0011) || (c == 4'b1011 && a[1:0] == 2'b01);
  endfunction

  function automatic logic ref_bytes(logic [31:0] a, logic [31:0] b, logic [3:0] ben);
    for (int k = 0; k < 4; k++)
      if (ben[k] == 1'b0 && a[8*k +: 8] != b[8*k +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    logic el, hit, fin, coll, tev, disc;
    int pre;
    if (!rst_n) begin
      m_cnt = 0; m_tmr = 0;
      {e_valid, e_claim, e_retry, e_done, e_stop, e_abort, e_disc} = '0;
    end else begin
      el = att_valid && ref_elig(att_cmd, att_addr);
      hit = 1'b0;
      for (int i = 0; i < m_cnt; i++)
        if (m_cmd[i] == att_cmd && m_addr[i] == att_addr) hit = 1'b1;
      fin  = (m_cnt > 0) && (m_st[0] != 0);
      coll = el && fin && m_cmd[0] == att_cmd && m_addr[0] == att_addr &&
             m_be[0] == att_be_n && ref_bytes(m_data[0], att_data, att_be_n);
      tev  = (tgt_done || tgt_err) && (m_cnt > 0) && (m_st[0] == 0) && order_ok;
      disc = fin && (m_tmr == 0) && !coll;
      e_valid = att_valid;
      e_claim = el;
      e_retry = el && !coll;
      e_done  = coll && m_st[0] == 1;
      e_abort = coll && m_st[0] == 2;
      e_stop  = e_done && att_multi;
      e_disc  = disc;
      if (tev) m_tmr = int'(discard_load);
      else if (fin && !(coll || disc) && m_tmr != 0) m_tmr--;
      if (tev) m_st[0] = tgt_done ? 1 : 2;
      pre = m_cnt;
      if (coll || disc) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          m_cmd[i] = m_cmd[i+1]; m_addr[i] = m_addr[i+1];
          m_be[i] = m_be[i+1]; m_data[i] = m_data[i+1]; m_st[i] = m_st[i+1];
        end
        m_cnt--;
      end
      if (el && !hit && pre < DEPTH) begin
        m_cmd[m_cnt] = att_cmd; m_addr[m_cnt] = att_addr;
        m_be[m_cnt] = att_be_n; m_data[m_cnt] = att_data; m_st[m_cnt] = 0;
        m_cnt++;
      end
    end
  end

  // Continuous comparison, one time unit after the falling edge
  always @(negedge clk) begin
    logic etv;
    #1;
    if (rst_n && !finished) begin
      etv = (m_cnt > 0) && (m_st[0] == 0) && order_ok;
      check("R2 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      check("R1 rsp_claim", 32'(rsp_claim), 32'(e_claim));
      check("R4 rsp_retry", 32'(rsp_retry), 32'(e_retry));
      check("R6 rsp_done",  32'(rsp_done),  32'(e_done));
      check("R6 rsp_stop",  32'(rsp_stop),  32'(e_stop));
      check("R8 rsp_abort", 32'(rsp_abort), 32'(e_abort));
      check("R9 discard",   32'(discard),   32'(e_disc));
      check("R3 full",      32'(full),      32'(m_cnt == DEPTH));
      check("R3 empty",     32'(empty),     32'(m_cnt == 0));
      check("R5 tgt_valid", 32'(tgt_valid), 32'(etv));
      if (etv) begin
        check("R5 tgt_addr", tgt_addr, m_addr[0]);
        check("R5 tgt_data", tgt_data, m_data[0]);
      end
    end
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic attempt(logic [3:0] c, logic [31:0] a, logic [3:0] ben,
                         logic [31:0] d, logic multi);
    att_valid = 1'b1; att_cmd = c; att_addr = a; att_be_n = ben;
    att_data = d; att_multi = multi;
    step();
    att_valid = 1'b0; att_multi = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed = 32'h5EED_0C41;
    void'($urandom(seed));
    repeat (4) step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    check("R10 empty", 32'(empty), 32'd1);
    check("R10 full", 32'(full), 32'd0);
    check("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R10 tgt_valid", 32'(tgt_valid), 32'd0);
    check("R10 discard", 32'(discard), 32'd0);

    // R1 ineligible commands
    attempt(4'b0111, 32'h0000_0100, 4'h0, D0, 1'b0);
    check("R1 memwr claim", 32'(rsp_claim), 32'd0);
    check("R1 memwr valid", 32'(rsp_valid), 32'd1);
    attempt(4'b1011, 32'h0000_0200, 4'h0, D0, 1'b0);
    check("R1 type0 claim", 32'(rsp_claim), 32'd0);
    check("R1 queue empty", 32'(empty), 32'd1);

    // R2 first attempt
    attempt(4'b0011, 32'h0000_1000, 4'b0010, D0, 1'b0);
    check("R2 claim", 32'(rsp_claim), 32'd1);
    check("R2 retry", 32'(rsp_retry), 32'd1);
    check("R2 stored", 32'(empty), 32'd0);

    // R4 early repeat
    attempt(4'b0011, 32'h0000_1000, 4'b0010, D0, 1'b0);
    check("R4 retry", 32'(rsp_retry), 32'd1);
    check("R4 no done", 32'(rsp_done), 32'd0);

    // R5 ordering gate
    step();
    check("R5 gated", 32'(tgt_valid), 32'd0);
    order_ok = 1'b1;
    #1;
    check("R5 offered", 32'(tgt_valid), 32'd1);
    check("R5 addr", tgt_addr, 32'h0000_1000);
    discard_load = 6'd5;
    tgt_done = 1'b1;
    step();
    tgt_done = 1'b0;
    check("R5 finished", 32'(tgt_valid), 32'd0);

    // R7 masked byte differs, R6 completion with disconnect
    attempt(4'b0011, 32'h0000_1000, 4'b0010, D1, 1'b1);
    check("R7 done", 32'(rsp_done), 32'd1);
    check("R6 stop", 32'(rsp_stop), 32'd1);
    check("R6 no retry", 32'(rsp_retry), 32'd0);
    step();
    check("R6 removed", 32'(empty), 32'd1);

    // R3 fill the queue
    order_ok = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      attempt(4'b0011, 32'h0000_2000 + 32'(i) * 32'h10, 4'h0, D0, 1'b0);
    check("R3 full", 32'(full), 32'd1);
    attempt(4'b0011, 32'h0000_3000, 4'h0, D0, 1'b0);
    check("R3 retry when full", 32'(rsp_retry), 32'd1);
    check("R3 still full", 32'(full), 32'd1);

    // R9 discard after load+1 cycles
    discard_load = 6'd2;
    order_ok = 1'b1;
    tgt_done = 1'b1;
    step();
    tgt_done = 1'b0;
    order_ok = 1'b0;
    step();
    check("R9 wait1", 32'(discard), 32'd0);
    step();
    check("R9 wait2", 32'(discard), 32'd0);
    step();
    check("R9 pulse", 32'(discard), 32'd1);
    check("R9 removed", 32'(full), 32'd0);

    // R8 failed head
    order_ok = 1'b1;
    tgt_err = 1'b1;
    step();
    tgt_err = 1'b0;
    attempt(4'b0011, 32'h0000_2010, 4'h0, D0, 1'b0);
    check("R8 abort", 32'(rsp_abort), 32'd1);
    check("R8 no done", 32'(rsp_done), 32'd0);

    // Random traffic against the model
    for (int cyc = 0; cyc < 6000; cyc++) begin
      int r;
      r = int'($urandom % 8);
      att_valid = ($urandom % 3) != 0;
      att_cmd = (r < 4) ? 4'b0011 : (r < 6) ? 4'b1011 : (r == 6) ? 4'b0111 : 4'b1010;
      att_addr = 32'h0000_4000 + 32'($urandom % 5) * 32'h100 +
                 ((($urandom % 4) != 0) ? 32'd1 : 32'd0);
      att_data = ($urandom % 2) ? D0 : D1;
      att_be_n = ($urandom % 2) ? 4'b0000 : 4'b0010;
      att_multi = $urandom % 2;
      order_ok = ($urandom % 5) != 0;
      tgt_done = ($urandom % 3) == 0;
      tgt_err = ($urandom % 8) == 0;
      if (cyc % 64 == 0) discard_load = TMR_W'($urandom % 7);
      step();
    end
    att_valid = 1'b0; tgt_done = 1'b0; tgt_err = 1'b0;
    step();
    summary();
  end
endmodule